// File: doc/BRIEF.md
# Width-Selectable Load and Add Unit

This unit runs one load, add or add-logical operation per cycle on a 64-bit register value (the first operand) and a second operand that has already been fetched from a register or from storage. An operand-form select decides how wide the operation is. The narrow form works on the low word only and leaves the high word of the register exactly as it was. The wide form works on all 64 bits. The mixed form widens a 32-bit second operand to 64 bits before it is combined with the full first operand. A separate load-address operation is modal: the addressing mode decides how much of the register it replaces.

Bits are numbered 0 to 63 from the most significant end, so the low word (bits 32-63) sits at vector positions `[31:0]`. The logic is combinational up to a single output register, which also carries a valid strobe. Register-file access, decode and storage access belong to the surrounding pipeline.

Top module: `widthsel_alu`

## Requirements
- R1: After a clock edge with `in_valid` high, `out_valid` is high for the next cycle, and it is low after any edge with `in_valid` low. A synchronous active-low reset clears `out_valid`, `result`, `cc` and `flag`.
- R2: In the narrow form (`form`=0), the low word of `result` is computed from the low words of both operands, and bits 0-31 of `result` equal bits 0-31 of `first`.
- R3: In the wide form (`form`=1), all 64 bits of both operands are used and all 64 bits of `result` are written.
- R4: In the mixed form (`form`=2), load (`op`=0) and add (`op`=2) sign-extend the low word of `second` to 64 bits before they operate.
- R5: In the mixed form, load-logical (`op`=1) and add-logical (`op`=3) zero-extend the low word of `second` to 64 bits.
- R6: Load-address (`op`=4) in 64-bit mode (`amode`=3) writes all 64 bits of `second` to `result`.
- R7: Load-address in 24-bit mode (`amode`=0) or 31-bit mode (`amode`=1 or 2) keeps bits 0-31 of `first`, and writes the low word of `second` with every bit above the 24 or 31 low-order bits cleared. The `form` input has no effect on it.
- R8: Load, load-logical, add and add-logical give the same `result`, `cc` and `flag` in every addressing mode.
- R9: Add sets `cc` to 0 for a zero result, 1 for a negative result, 2 for a positive result and 3 on signed overflow, all judged at the operation width (32 bits in the narrow form, 64 bits otherwise). `flag` is the overflow.
- R10: Add-logical sets `cc` = {carry out of the operation width, result nonzero}, which gives 0/1/2/3, and `flag` is the carry.
- R11: Load, load-logical and load-address set `cc` to 0 and `flag` to 0. Codes 5-7 of `op` behave as load, and `form`=3 behaves as the narrow form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 3 | 0 load, 1 load logical, 2 add, 3 add logical, 4 load address |
| form | input | 2 | 0 narrow 32-bit, 1 wide 64-bit, 2 mixed 64/32 |
| amode | input | 2 | 0 24-bit, 1 or 2 31-bit, 3 64-bit addressing |
| first | input | 64 | Current value of the first-operand register |
| second | input | 64 | Second operand (register, storage or computed address) |
| out_valid | output | 1 | Registered result is valid |
| result | output | 64 | Value to write back to the first-operand register |
| cc | output | 2 | Condition code |
| flag | output | 1 | Overflow (add) or carry (add logical) |

## Verification
Two cases are the hardest to reach. One is the point where a narrow add overflows or carries at bit 32 while the high words of both operands hold values that would change the answer if they leaked in. The other is the same wide sum shown under each of the four addressing modes. The stimulus places operands right at the word boundaries, such as 0x7FFFFFFF + 1 and 0xFFFFFFFF + 1, and sets their high words to distinct patterns. It then repeats identical operations with only `amode` changed, so that any dependence of a non-modal form on the mode shows as a mismatch. A long run of random operands, with every op/form/mode combination, follows the directed cases.

// File: rtl/wsa_pkg.sv
// Shared encodings for the width-selectable load/add unit.
// Assumes: operation, form and mode codes are fixed by the surrounding decode.
package wsa_pkg;
    typedef enum logic [2:0] {
        OP_LOAD  = 3'd0,
        OP_LOADL = 3'd1,
        OP_ADD   = 3'd2,
        OP_ADDL  = 3'd3,
        OP_LADDR = 3'd4
    } op_e;

    typedef enum logic [1:0] {
        FM_NARROW = 2'd0,
        FM_WIDE   = 2'd1,
        FM_MIXED  = 2'd2
    } form_e;

    typedef enum logic [1:0] {
        AM_24 = 2'd0,
        AM_31 = 2'd1,
        AM_64 = 2'd3
    } amode_e;
endpackage

// File: rtl/wsa_extend.sv
// Second-operand shaper: delivers the operand the adder sees.
// Narrow form passes the low word (high bits zero), wide passes all bits,
// mixed form widens the low word by sign (arithmetic ops) or zeros (logical ops).
// Assumes: DW is even; the narrow adder path ignores the upper half.
module wsa_extend #(
    parameter int DW = 64
) (
    input  logic [2:0]    op,
    input  logic [1:0]    form,
    input  logic [DW-1:0] sec,
    output logic [DW-1:0] opnd
);
    import wsa_pkg::*;
    localparam int HW = DW / 2;

    logic logical_op;

    // Decide the extension kind: logical ops extend by zeros.
    always_comb begin
        logical_op = (op == OP_LOADL) || (op == OP_ADDL);
    end

    // Shape the operand according to the form.
    always_comb begin
        unique case (form)
            FM_WIDE:  opnd = sec;
            FM_MIXED: opnd = logical_op ? {{HW{1'b0}}, sec[HW-1:0]}
                                        : {{HW{sec[HW-1]}}, sec[HW-1:0]};
            default:  opnd = {{HW{1'b0}}, sec[HW-1:0]};
        endcase
    end
endmodule

// File: rtl/wsa_adder.sv
// Width-aware add with condition code.
// Computes a+b at either half width (narrow) or full width, and derives the
// arithmetic or logical condition code. Load-type ops pass b with cc 0.
// Assumes: for narrow, only the low half of the sum is consumed downstream.
module wsa_adder #(
    parameter int DW = 64
) (
    input  logic [2:0]    op,
    input  logic          narrow,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] sum,
    output logic [1:0]    cc,
    output logic          flag
);
    import wsa_pkg::*;
    localparam int HW = DW / 2;

    logic [DW:0]   full_s;
    logic [HW:0]   half_s;
    logic [DW-1:0] raw;
    logic          c_out;
    logic          sgn_a;
    logic          sgn_b;
    logic          sgn_r;
    logic          is_zero;
    logic          ovf;

    // Both width adders in parallel.
    always_comb begin
        full_s = {1'b0, a} + {1'b0, b};
        half_s = {1'b0, a[HW-1:0]} + {1'b0, b[HW-1:0]};
    end

    // Select the width-specific sum and the sign and carry bits.
    always_comb begin
        if (narrow) begin
            raw   = {{HW{1'b0}}, half_s[HW-1:0]};
            c_out = half_s[HW];
            sgn_a = a[HW-1];
            sgn_b = b[HW-1];
            sgn_r = half_s[HW-1];
        end else begin
            raw   = full_s[DW-1:0];
            c_out = full_s[DW];
            sgn_a = a[DW-1];
            sgn_b = b[DW-1];
            sgn_r = full_s[DW-1];
        end
        is_zero = (raw == '0);
        ovf     = (sgn_a == sgn_b) && (sgn_r != sgn_a);
    end

    // Result and condition code per operation class.
    always_comb begin
        unique case (op)
            OP_ADD: begin
                sum  = raw;
                flag = ovf;
                if (ovf)          cc = 2'd3;
                else if (is_zero) cc = 2'd0;
                else if (sgn_r)   cc = 2'd1;
                else              cc = 2'd2;
            end
            OP_ADDL: begin
                sum  = raw;
                flag = c_out;
                cc   = {c_out, ~is_zero};
            end
            default: begin
                sum  = b;
                flag = 1'b0;
                cc   = 2'd0;
            end
        endcase
    end
endmodule

// File: rtl/wsa_writeback.sv
// Write-width merge: builds the 64-bit value returned to the register.
// Narrow ops keep the register's high half; load-address is modal and clears
// low-word bits above the short or mid address width unless in 64-bit mode.
// Assumes: A_SHORT < A_MID < HW.
module wsa_writeback #(
    parameter int DW      = 64,
    parameter int A_SHORT = 24,
    parameter int A_MID   = 31
) (
    input  logic [2:0]    op,
    input  logic [1:0]    form,
    input  logic [1:0]    amode,
    input  logic [DW-1:0] first,
    input  logic [DW-1:0] sec,
    input  logic [DW-1:0] alu_sum,
    output logic [DW-1:0] wb
);
    import wsa_pkg::*;
    localparam int HW = DW / 2;
    localparam logic [HW-1:0] MASK_SHORT = {{(HW-A_SHORT){1'b0}}, {A_SHORT{1'b1}}};
    localparam logic [HW-1:0] MASK_MID   = {{(HW-A_MID){1'b0}}, {A_MID{1'b1}}};

    logic [HW-1:0] la_mask;

    // Pick the address mask for the current mode.
    always_comb begin
        unique case (amode)
            AM_24:   la_mask = MASK_SHORT;
            default: la_mask = MASK_MID;
        endcase
    end

    // Merge the written field with the preserved field.
    always_comb begin
        if (op == OP_LADDR) begin
            if (amode == AM_64) wb = sec;
            else                wb = {first[DW-1:HW], sec[HW-1:0] & la_mask};
        end else if (form == FM_WIDE || form == FM_MIXED) begin
            wb = alu_sum;
        end else begin
            wb = {first[DW-1:HW], alu_sum[HW-1:0]};
        end
    end
endmodule

// File: rtl/widthsel_alu.sv
// Top of the width-selectable load/add unit: operand shaping, width-aware add,
// write-width merge, then one result register with valid strobe.
// Assumes: inputs are stable around the rising edge; one op per cycle.
module widthsel_alu #(
    parameter int DW      = 64,
    parameter int A_SHORT = 24,
    parameter int A_MID   = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [2:0]    op,
    input  logic [1:0]    form,
    input  logic [1:0]    amode,
    input  logic [DW-1:0] first,
    input  logic [DW-1:0] second,
    output logic          out_valid,
    output logic [DW-1:0] result,
    output logic [1:0]    cc,
    output logic          flag
);
    import wsa_pkg::*;
    localparam int HW = DW / 2;

    logic [DW-1:0] opnd_b;
    logic [DW-1:0] sum_w;
    logic [DW-1:0] wb_w;
    logic [1:0]    cc_w;
    logic          flag_w;
    logic          narrow_w;

    // Narrow width unless wide or mixed form is selected.
    always_comb begin
        narrow_w = !(form == FM_WIDE || form == FM_MIXED);
    end

    wsa_extend #(.DW(DW)) u_ext (
        .op   (op),
        .form (form),
        .sec  (second),
        .opnd (opnd_b)
    );

    wsa_adder #(.DW(DW)) u_add (
        .op     (op),
        .narrow (narrow_w),
        .a      (first),
        .b      (opnd_b),
        .sum    (sum_w),
        .cc     (cc_w),
        .flag   (flag_w)
    );

    wsa_writeback #(.DW(DW), .A_SHORT(A_SHORT), .A_MID(A_MID)) u_wb (
        .op      (op),
        .form    (form),
        .amode   (amode),
        .first   (first),
        .sec     (second),
        .alu_sum (sum_w),
        .wb      (wb_w)
    );

    // Output register: captures the result when an operation is presented.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            cc        <= 2'd0;
            flag      <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= wb_w;
                cc     <= cc_w;
                flag   <= flag_w;
            end
        end
    end

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_VALID_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R1
    AST_HIGH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != OP_LADDR && form == FM_NARROW)
        |=> result[DW-1:HW] == $past(first[DW-1:HW])); // R2
    AST_MIX_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_LOAD && form == FM_MIXED && second[HW-1])
        |=> result[DW-1:HW] == '1); // R4
    AST_MIX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_LOADL && form == FM_MIXED)
        |=> result[DW-1:HW] == '0); // R5
    AST_LA_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_LADDR && amode == AM_24)
        |=> (result[HW-1:A_SHORT] == '0) && (result[DW-1:HW] == $past(first[DW-1:HW]))); // R7
    AST_LOAD_NOFLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_LOAD || op == OP_LOADL || op == OP_LADDR))
        |=> (cc == 2'd0) && !flag); // R11
endmodule

// File: tb/widthsel_alu_test.sv
module widthsel_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  form = '0;
    logic [1:0]  amode = '0;
    logic [63:0] first = '0;
    logic [63:0] second = '0;
    logic        out_valid;
    logic [63:0] result;
    logic [1:0]  cc;
    logic        flag;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;

    widthsel_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .form(form),
        .amode(amode), .first(first), .second(second), .out_valid(out_valid),
        .result(result), .cc(cc), .flag(flag)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural reference: integer arithmetic on the requirement text.
    task automatic model(input logic [2:0] o, input logic [1:0] f, input logic [1:0] m,
                         input logic [63:0] a, input logic [63:0] s,
                         output logic [63:0] r, output logic [1:0] c, output logic fl);
        logic [64:0] t;
        logic [63:0] b;
        int w;
        bit neg, z, cy, ov;
        r = 0; c = 0; fl = 0;
        if (o == 3'd4) begin
            if (m == 2'd3) r = s;
            else if (m == 2'd0) r = {a[63:32], 8'h00, s[23:0]};
            else r = {a[63:32], 1'b0, s[30:0]};
            return;
        end
        w = (f == 2'd1 || f == 2'd2) ? 64 : 32;
        if (f == 2'd2) b = (o == 3'd1 || o == 3'd3) ? {32'h0, s[31:0]} : {{32{s[31]}}, s[31:0]};
        else if (f == 2'd1) b = s;
        else b = {32'h0, s[31:0]};
        if (o == 3'd2 || o == 3'd3) begin
            if (w == 64) begin
                t = {1'b0, a} + {1'b0, b};
                cy = t[64]; neg = t[63]; z = (t[63:0] == 0);
                ov = (a[63] == b[63]) && (t[63] != a[63]);
                r = t[63:0];
            end else begin
                t = {33'h0, a[31:0]} + {33'h0, b[31:0]};
                cy = t[32]; neg = t[31]; z = (t[31:0] == 0);
                ov = (a[31] == b[31]) && (t[31] != a[31]);
                r = {a[63:32], t[31:0]};
            end
            if (o == 3'd2) begin
                fl = ov;
                c = ov ? 2'd3 : z ? 2'd0 : neg ? 2'd1 : 2'd2;
            end else begin
                fl = cy;
                c = {cy, !z};
            end
        end else begin
            r = (w == 64) ? b : {a[63:32], b[31:0]};
        end
    endtask

    // Drive one op at the falling edge, check at the next falling edge.
    task automatic run(input string tag, input logic [2:0] o, input logic [1:0] f,
                       input logic [1:0] m, input logic [63:0] a, input logic [63:0] s);
        logic [63:0] er;
        logic [1:0]  ec;
        logic        ef;
        model(o, f, m, a, s, er, ec, ef);
        in_valid = 1'b1; op = o; form = f; amode = m; first = a; second = s;
        @(negedge clk);
        check({tag, " valid R1"}, {63'h0, out_valid}, 64'h1);
        check({tag, " result"}, result, er);
        check({tag, " cc"}, {62'h0, cc}, {62'h0, ec});
        check({tag, " flag"}, {63'h0, flag}, {63'h0, ef});
    endtask

    initial begin
        repeat (120000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", {63'h0, out_valid}, 64'h0);
        check("R1 reset result", result, 64'h0);
        check("R1 reset cc", {62'h0, cc, flag}, 64'h0);
        rst_n = 1'b1;
        // Narrow forms keep the high word
        run("R2 narrow load", 3'd0, 2'd0, 2'd3, 64'hDEADBEEF_11111111, 64'hAAAAAAAA_22222222);
        run("R2 narrow add ovf R9", 3'd2, 2'd0, 2'd1, 64'h12345678_7FFFFFFF, 64'h0F0F0F0F_00000001);
        run("R2 narrow addl carry R10", 3'd3, 2'd0, 2'd0, 64'hCAFEF00D_FFFFFFFF, 64'h00000000_00000001);
        run("R11 form3 narrow", 3'd2, 2'd3, 2'd3, 64'h55555555_00000005, 64'h99999999_FFFFFFFB);
        // Wide forms
        run("R3 wide add", 3'd2, 2'd1, 2'd0, 64'h00000001_FFFFFFFF, 64'h00000000_00000001);
        run("R3 wide add ovf R9", 3'd2, 2'd1, 2'd1, 64'h7FFFFFFF_FFFFFFFF, 64'h1);
        run("R9 wide add neg", 3'd2, 2'd1, 2'd3, 64'h0, 64'hFFFFFFFF_FFFFFFFE);
        run("R10 wide addl zero carry", 3'd3, 2'd1, 2'd3, 64'hFFFFFFFF_FFFFFFFF, 64'h1);
        // Mixed forms
        run("R4 mixed load sign", 3'd0, 2'd2, 2'd1, 64'h1234, 64'h00000000_80000000);
        run("R4 mixed add sign", 3'd2, 2'd2, 2'd0, 64'h00000001_00000000, 64'hFFFF0000_FFFFFFFF);
        run("R5 mixed loadl zero", 3'd1, 2'd2, 2'd3, 64'h1234, 64'hFFFFFFFF_80000000);
        run("R5 mixed addl zero", 3'd3, 2'd2, 2'd0, 64'h00000001_00000000, 64'hFFFF0000_FFFFFFFF);
        // Load address
        run("R6 laddr 64", 3'd4, 2'd0, 2'd3, 64'h1111, 64'hFEDCBA98_76543210);
        run("R7 laddr 24", 3'd4, 2'd1, 2'd0, 64'hABCD0123_FFFFFFFF, 64'hFEDCBA98_FFFFFFFF);
        run("R7 laddr 31", 3'd4, 2'd2, 2'd1, 64'hABCD0123_00000000, 64'hFEDCBA98_FFFFFFFF);
        run("R7 laddr 31 code2", 3'd4, 2'd1, 2'd2, 64'h0, 64'hFFFFFFFF_FFFFFFFF);
        run("R11 op7 as load", 3'd7, 2'd1, 2'd0, 64'h5, 64'h8000000000000000);
        // Same op in each mode
        for (int m = 0; m < 4; m++) begin
            run("R8 mode sweep wide", 3'd2, 2'd1, m[1:0], 64'h7FFFFFFF_00000000, 64'h00000001_00000000);
            run("R8 mode sweep narrow", 3'd3, 2'd0, m[1:0], 64'h0000FFFF_80000000, 64'h0000FFFF_80000000);
        end
        // Idle cycle drops valid
        in_valid = 1'b0;
        @(negedge clk);
        check("R1 idle valid", {63'h0, out_valid}, 64'h0);
        // Random sweep
        for (int i = 0; i < 2000; i++) begin
            logic [63:0] ra, rs;
            ra = {$urandom, $urandom};
            rs = {$urandom, $urandom};
            if (i % 4 == 0) rs[31:0] = ~ra[31:0] + 32'(i % 3);
            run("R8 random", 3'($urandom % 8), 2'($urandom % 4), 2'($urandom % 4), ra, rs);
        end
        in_valid = 1'b0;
        @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule